// File: doc/BRIEF.md
# Windowed Transmit Message Queue

This block is a small queue of outgoing CAN messages that a host fills through one fixed register window. The host writes an identifier word, a length code and up to eight data bytes into the window. It then writes a commit key to a pointer register, and the window contents become the newest queued message. The host never addresses a queue slot directly. The identifier word is stored and passed on unchanged. By convention bit 31 marks an extended identifier, bit 30 marks a remote request, a standard identifier occupies bits 28:18, and an extended identifier occupies bits 28:0.

The oldest queued message is presented to a stubbed protocol engine together with a valid flag. The engine answers with a one-cycle `tx_done` pulse once the message has gone out, and the block then drops that entry and raises a sent flag in an interrupt status register. Through a control register the host reads how many committed messages are still unsent, sets the queue enable, and sees a sticky overflow flag. Bus framing, arbitration and bit timing are outside this block.

Register addresses (`host_addr` / `host_rd_addr`): 0 identifier word, 1 length code, 2 control, 3 pointer (write only, reads 0), 4 interrupt status, 5 interrupt enable, 8 to 15 data bytes 0 to 7 (each in bits 7:0). Every other address reads 0.

Top module: `can_txq_window`

## Requirements
- R1: After a synchronous active-low reset the control register, interrupt status and interrupt enable read 0, and `tx_valid` and `irq` are low.
- R2: Writes to address 0 store the full 32-bit identifier word. Writes to address 1 keep only bits 3:0 as the length code, and upper bits read back 0. Writes to addresses 8 to 15 store bits 7:0 as data byte 0 to 7. All of these read back through the same addresses.
- R3: A write of 0xFF in bits 7:0 to address 3 appends the window contents while the queue is enabled and holds fewer than 4 entries. Any other value written there changes nothing.
- R4: Control register bit 0 is the queue enable (read/write), and bits 3:1 read the number of committed but unsent entries (0 to 4).
- R5: A commit with 4 entries unsent is dropped and the count stays unchanged. The commit sets a sticky overflow flag at control bit 4, which stays set until a control write with bit 4 at 0.
- R6: A control write with bit 0 at 0 empties the queue. While the enable is low, commits are discarded without setting overflow, the unsent count reads 0, `tx_valid` is low and `tx_done` is ignored.
- R7: Entries leave in commit order. While the count is nonzero, `tx_valid` is high and `tx_id`, `tx_dlc` and `tx_data` (byte k in bits 8k+7:8k) show the oldest entry. A `tx_done` pulse removes it and lowers the count by one at the next edge.
- R8: An accepted `tx_done` sets interrupt status bit 3 (address 4). `irq` equals that bit ANDed with interrupt enable bit 3 (address 5).
- R9: Writing 0 to status bit 3 clears it and writing 1 leaves it unchanged. A send in the same cycle as a clearing write leaves the bit set.
- R10: `tx_done` while the queue is empty changes neither the count nor the status bit.
- R11: A commit and an accepted `tx_done` in the same cycle both take effect, so the count is unchanged and the new entry goes to the tail. If the queue held 4 entries, the commit is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one register per cycle |
| host_addr | input | 4 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_rd_addr | input | 4 | Host read address |
| host_rdata | output | 32 | Read data for `host_rd_addr` (combinational) |
| tx_valid | output | 1 | Queue holds at least one unsent entry |
| tx_id | output | 32 | Identifier word of the oldest entry |
| tx_dlc | output | 4 | Length code of the oldest entry |
| tx_data | output | 64 | Data bytes of the oldest entry |
| tx_done | input | 1 | One-cycle pulse: oldest entry has been sent |
| irq | output | 1 | Sent interrupt, status bit 3 gated by enable bit 3 |

## Verification
The bench targets commits into a full queue. A design that wrapped the write pointer there would overwrite the oldest unsent message and show a wrong head or a count of zero. It also drives commits that coincide with a send pulse, where a design that let one event mask the other would drift the count away from the model. It writes 1 and 0 to the status bit, including a clear in the same cycle as a send, which catches a toggle-on-write or clear-wins design. It also disables the queue with entries pending and sends done pulses into an empty queue, where a faulty design would keep stale entries or raise the status bit spuriously.

// File: rtl/can_txq_pkg.sv
// Shared constants and the queue entry type for the windowed transmit queue.
// Assumes a 4-bit register address space and 8 data bytes per message.
package can_txq_pkg;
    localparam int ID_W       = 32;
    localparam int DLC_W      = 4;
    localparam int DATA_BYTES = 8;
    localparam int DATA_W     = DATA_BYTES * 8;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] A_ID    = 4'd0;
    localparam logic [ADDR_W-1:0] A_DLC   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd2;
    localparam logic [ADDR_W-1:0] A_PTR   = 4'd3;
    localparam logic [ADDR_W-1:0] A_ISTAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd5;

    localparam logic [7:0] COMMIT_KEY = 8'hFF;
    localparam int B_EN      = 0;
    localparam int B_CNT_LSB = 1;
    localparam int B_SENT    = 3;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } txq_entry_t;
endpackage

// File: rtl/can_txq_store.sv
// Circular storage for queued messages with read/write pointers and an
// occupancy count. Assumes the caller never pushes when full nor pops when
// empty; flush has priority over push and pop.
module can_txq_store
    import can_txq_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  txq_entry_t       push_entry,
    output txq_entry_t       head_entry,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    txq_entry_t       slots [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // One register bank per slot, loaded when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(i)) slots[i] <= push_entry;
        end
    end

    assign head_entry = slots[rd_ptr];

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < FULL_CNT);
    p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/can_txq_host.sv
// Host side: holds the message window, the enable and overflow bits, and
// decodes commit, send and flush events. Assumes one register write per cycle.
module can_txq_host
    import can_txq_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int B_OVF = B_CNT_LSB + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              tx_done,
    output txq_entry_t        win,
    output logic              fifo_en,
    output logic              ovf,
    output logic              push,
    output logic              pop,
    output logic              flush
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic wr_ctrl, commit_try, full;

    assign wr_ctrl    = host_wr && host_addr == A_CTRL;
    assign commit_try = host_wr && host_addr == A_PTR && host_wdata[7:0] == COMMIT_KEY;
    assign full       = count == FULL_CNT;
    assign flush      = wr_ctrl && !host_wdata[B_EN];
    assign push       = commit_try && fifo_en && !full;
    assign pop        = tx_done && fifo_en && count != '0 && !flush;

    // Message window: identifier, length code and byte-addressed data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (host_wr) begin
            if (host_addr == A_ID)  win.id  <= host_wdata;
            if (host_addr == A_DLC) win.dlc <= host_wdata[DLC_W-1:0];
            if (host_addr[3])       win.data[{host_addr[2:0], 3'b000} +: 8] <= host_wdata[7:0];
        end
    end

    // Queue enable and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                fifo_en <= host_wdata[B_EN];
                if (!host_wdata[B_OVF]) ovf <= 1'b0;
            end
            if (commit_try && fifo_en && full) ovf <= 1'b1;
        end
    end

    p_full_commit_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_try && full && !tx_done) |=> count == FULL_CNT);
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_ctrl && !host_wdata[B_OVF])) |=> ovf);
    p_off_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> count == '0);
    p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_PTR && host_wdata[7:0] != COMMIT_KEY && !tx_done)
        |=> $stable(count));
endmodule

// File: rtl/can_txq_irq.sv
// Sent-interrupt status and enable. A send sets the status bit; a host
// write of 0 to it clears it, a write of 1 does nothing; set wins.
module can_txq_irq
    import can_txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              sent,
    output logic              sent_stat,
    output logic              sent_en,
    output logic              irq
);
    logic clr_req;
    assign clr_req = host_wr && host_addr == A_ISTAT && !host_wdata[B_SENT];

    // Status bit with set priority over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       sent_stat <= 1'b0;
        else if (sent)    sent_stat <= 1'b1;
        else if (clr_req) sent_stat <= 1'b0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 sent_en <= 1'b0;
        else if (host_wr && host_addr == A_IEN)     sent_en <= host_wdata[B_SENT];
    end

    assign irq = sent_stat && sent_en;

    p_send_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sent |=> sent_stat);
    p_write_one_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_ISTAT && host_wdata[B_SENT] && !sent_stat && !sent)
        |=> !sent_stat);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !sent) |=> !sent_stat);
endmodule

// File: rtl/can_txq_window.sv
// Top of the windowed transmit queue: wires host decode, storage and the
// interrupt logic, and drives the combinational register read port.
module can_txq_window
    import can_txq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [3:0]  host_addr,
    input  logic [31:0] host_wdata,
    input  logic [3:0]  host_rd_addr,
    output logic [31:0] host_rdata,
    output logic        tx_valid,
    output logic [31:0] tx_id,
    output logic [3:0]  tx_dlc,
    output logic [63:0] tx_data,
    input  logic        tx_done,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int B_OVF = B_CNT_LSB + CNT_W;

    txq_entry_t       win, head;
    logic [CNT_W-1:0] count;
    logic             fifo_en, ovf, push, pop, flush, sent_stat, sent_en;

    can_txq_host #(.DEPTH(DEPTH)) u_host (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .count(count), .tx_done(tx_done), .win(win),
        .fifo_en(fifo_en), .ovf(ovf), .push(push), .pop(pop), .flush(flush)
    );

    can_txq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
        .push_entry(win), .head_entry(head), .count(count)
    );

    can_txq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .sent(pop), .sent_stat(sent_stat),
        .sent_en(sent_en), .irq(irq)
    );

    assign tx_valid = count != '0;
    assign tx_id    = head.id;
    assign tx_dlc   = head.dlc;
    assign tx_data  = head.data;

    // Register read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_rd_addr)
            A_ID:    host_rdata = win.id;
            A_DLC:   host_rdata[DLC_W-1:0] = win.dlc;
            A_CTRL: begin
                host_rdata[B_EN]                = fifo_en;
                host_rdata[B_CNT_LSB +: CNT_W]  = count;
                host_rdata[B_OVF]               = ovf;
            end
            A_ISTAT: host_rdata[B_SENT] = sent_stat;
            A_IEN:   host_rdata[B_SENT] = sent_en;
            default: if (host_rd_addr[3])
                         host_rdata[7:0] = win.data[{host_rd_addr[2:0], 3'b000} +: 8];
        endcase
    end

    p_done_pops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_valid && !push && !flush) |=> int'(count) == int'($past(count)) - 1);
    p_empty_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_valid && !push && !flush) |=> count == '0);
    p_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count));
endmodule

// File: tb/tb_can_txq_window.sv
`timescale 1ns/1ps
module tb_can_txq_window;
    import can_txq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_rd_addr = '0;
    logic [31:0] host_rdata;
    logic        tx_valid;
    logic [31:0] tx_id;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        tx_done = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    can_txq_window dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rd_addr(host_rd_addr), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data),
        .tx_done(tx_done), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic        m_en, m_ovf, m_ist, m_ien;
    int          m_cnt, m_head;
    logic [31:0] m_wid;
    logic [3:0]  m_wdlc;
    logic [63:0] m_wdata;
    logic [31:0] mq_id   [4];
    logic [3:0]  mq_dlc  [4];
    logic [63:0] mq_data [4];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        v[0]   = m_en;
        v[3:1] = 3'(m_cnt);
        v[4]   = m_ovf;
        return v;
    endfunction

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        host_rd_addr = a;
        #0.2;
        v = host_rdata;
    endtask

    // Compare all observable state with the model (called in the low phase).
    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(A_CTRL, v);  chk("R4", {tag, " ctrl"}, 64'(v), 64'(exp_ctrl()));
        rd(A_ISTAT, v); chk("R8", {tag, " status"}, 64'(v), 64'({m_ist, 3'b000}));
        chk("R8", {tag, " irq"}, 64'(irq), 64'(m_ist & m_ien));
        chk("R7", {tag, " tx_valid"}, 64'(tx_valid), 64'(m_cnt != 0));
        if (m_cnt != 0) begin
            chk("R7", {tag, " head id"}, 64'(tx_id), 64'(mq_id[m_head]));
            chk("R7", {tag, " head dlc"}, 64'(tx_dlc), 64'(mq_dlc[m_head]));
            chk("R7", {tag, " head data"}, tx_data, mq_data[m_head]);
        end
    endtask

    task automatic model_update(input logic w, input logic [3:0] a,
                                input logic [31:0] d, input logic dn);
        logic fl, pp, cm;
        int   tail;
        fl   = w && a == A_CTRL && !d[0];
        pp   = dn && m_en && m_cnt > 0 && !fl;
        cm   = w && a == A_PTR && d[7:0] == 8'hFF && m_en;
        tail = (m_head + m_cnt) % 4;
        if (pp) m_ist = 1'b1;
        else if (w && a == A_ISTAT && !d[3]) m_ist = 1'b0;
        if (w && a == A_IEN) m_ien = d[3];
        if (w && a == A_ID)  m_wid = d;
        if (w && a == A_DLC) m_wdlc = d[3:0];
        if (w && a[3])       m_wdata[8*int'(a[2:0]) +: 8] = d[7:0];
        if (w && a == A_CTRL) begin
            m_en = d[0];
            if (!d[4]) m_ovf = 1'b0;
        end
        if (cm && m_cnt == 4) m_ovf = 1'b1;
        if (fl) begin
            m_cnt = 0; m_head = 0;
        end else begin
            if (cm && m_cnt < 4) begin
                mq_id[tail] = m_wid; mq_dlc[tail] = m_wdlc; mq_data[tail] = m_wdata;
            end
            if (pp) begin m_head = (m_head + 1) % 4; m_cnt--; end
            if (cm && (m_cnt < 4 || pp) && !(m_cnt + (pp ? 1 : 0) == 4)) m_cnt++;
        end
    endtask

    // One clock cycle of stimulus; returns at the following falling edge.
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d, input logic dn);
        host_wr = w; host_addr = a; host_wdata = d; tx_done = dn;
        model_update(w, a, d, dn);
        @(negedge clk);
        host_wr = 1'b0; tx_done = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic load_msg(input logic [31:0] id, input logic [3:0] dl, input logic [63:0] dat);
        wr(A_ID, id);
        wr(A_DLC, {28'h0, dl});
        for (int k = 0; k < 8; k++) wr(4'(8 + k), {24'h0, dat[8*k +: 8]});
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        m_en = 0; m_ovf = 0; m_ist = 0; m_ien = 0; m_cnt = 0; m_head = 0;
        m_wid = '0; m_wdlc = '0; m_wdata = '0;
        for (int i = 0; i < 4; i++) begin mq_id[i] = '0; mq_dlc[i] = '0; mq_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v);  chk("R1", "ctrl after reset", 64'(v), 64'h0);
        rd(A_ISTAT, v); chk("R1", "status after reset", 64'(v), 64'h0);
        rd(A_IEN, v);   chk("R1", "irq enable after reset", 64'(v), 64'h0);
        chk("R1", "tx_valid after reset", 64'(tx_valid), 64'h0);
        chk("R1", "irq after reset", 64'(irq), 64'h0);

        // R2 window write/readback; upper length bits dropped
        load_msg(32'h8ABC_DEF1, 4'h8, 64'h8877_6655_4433_2211);
        wr(A_DLC, 32'hFFFF_FFF7);
        rd(A_ID, v);  chk("R2", "id readback", 64'(v), 64'h8ABC_DEF1);
        rd(A_DLC, v); chk("R2", "dlc readback", 64'(v), 64'h7);
        rd(4'd13, v); chk("R2", "data byte 5", 64'(v), 64'h66);

        // R6 commit while disabled is discarded, no overflow
        wr(A_PTR, 32'hFF);
        check_all("R6 commit disabled");

        // R3 enable, wrong key ignored, then commits
        wr(A_CTRL, 32'h1);
        wr(A_PTR, 32'hFE);
        check_all("R3 wrong key");
        wr(A_PTR, 32'hFF);
        check_all("R3 first commit");
        for (int n = 0; n < 3; n++) begin
            load_msg(32'h0040_0000 * 32'(n + 1), 4'(n + 2), {8{8'(8'h30 + n)}});
            wr(A_PTR, 32'hFF);
        end
        check_all("R5 filled");
        // R5 commit into a full queue
        wr(A_ID, 32'hDEAD_BEEF);
        wr(A_PTR, 32'hFF);
        check_all("R5 overflow");
        rd(A_CTRL, v); chk("R5", "overflow bit set", 64'(v[4]), 64'h1);

        // R11 full queue: commit and done together, commit still dropped
        cyc(1'b1, A_PTR, 32'hFF, 1'b1);
        check_all("R11 full commit+done");
        // R11 commit and done together with room
        cyc(1'b1, A_PTR, 32'hFF, 1'b1);
        check_all("R11 commit+done");

        // R8 irq gating
        wr(A_IEN, 32'h8);
        check_all("R8 enable irq");
        // R9 writing 1 keeps, 0 clears, send wins over clear
        wr(A_ISTAT, 32'h8);
        check_all("R9 write one");
        wr(A_ISTAT, 32'h0);
        check_all("R9 write zero");
        cyc(1'b1, A_ISTAT, 32'h0, 1'b1);
        check_all("R9 send beats clear");

        // R7 drain in order
        while (m_cnt > 0) begin
            cyc(1'b0, 4'h0, 32'h0, 1'b1);
            check_all("R7 drain");
        end
        // R10 done on empty queue
        wr(A_ISTAT, 32'h0);
        cyc(1'b0, 4'h0, 32'h0, 1'b1);
        check_all("R10 empty done");

        // R5 overflow cleared by ctrl write with bit4 = 0
        wr(A_CTRL, 32'h1);
        check_all("R5 overflow clear");

        // R6 disable flushes pending entries, done ignored
        wr(A_PTR, 32'hFF); wr(A_PTR, 32'hFF);
        wr(A_CTRL, 32'h0);
        check_all("R6 flush");
        wr(A_ISTAT, 32'h0);
        cyc(1'b0, 4'h0, 32'h0, 1'b1);
        check_all("R6 done while off");
        wr(A_CTRL, 32'h1);

        // Constrained random traffic
        for (int c = 0; c < 3000; c++) begin
            int r;
            logic dn;
            logic [3:0] a;
            logic [31:0] d;
            r  = int'($urandom % 100);
            dn = ($urandom % 3) == 0;
            d  = $urandom;
            if (r < 30) begin
                case ($urandom % 3)
                    0: a = A_ID;
                    1: a = A_DLC;
                    default: a = 4'(8 + ($urandom % 8));
                endcase
                cyc(1'b1, a, d, dn);
            end else if (r < 60) begin
                cyc(1'b1, A_PTR, (($urandom % 8) == 0) ? d : 32'hFF, dn);
            end else if (r < 63) begin
                d[0] = ($urandom % 5) != 0;
                cyc(1'b1, A_CTRL, d, dn);
            end else if (r < 70) begin
                cyc(1'b1, A_ISTAT, d, dn);
            end else if (r < 72) begin
                cyc(1'b1, A_IEN, d, dn);
            end else begin
                cyc(1'b0, 4'h0, 32'h0, dn);
            end
            check_all("R11 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule